// File: doc/BRIEF.md
# Ternary Weight Threshold Quantizer

This block takes the signed fixed-point weights of one tensor as a stream and turns each one into a three-level code. It works in two passes over the same data.

In the first pass it stores every weight in an internal buffer and adds up their magnitudes. When the last weight has arrived, it divides that sum by the element count to get the mean magnitude, and that mean becomes the dead-zone threshold. In the second pass it reads the buffer back in arrival order. Each weight is compared with plus and minus the threshold, and a 2-bit code goes out on an output stream that the consumer can stall.

A per-tensor scale factor, used later to rebuild the weights, is kept in a plain register next to the datapath. It never touches the codes. Software or a neighbouring block starts a tensor with a one-cycle start pulse and a length exponent. The block answers with a one-cycle done pulse once the final code has been taken.

Top module: `ternary_quantizer`

## Requirements
- R1: Every code on `out_code` while `out_valid` is high is one of three values: 2'b01 for +1, 2'b00 for 0 and 2'b11 for -1. The value 2'b10 never appears.
- R2: A weight strictly above the threshold produces 2'b01.
- R3: A weight strictly below the negated threshold produces 2'b11.
- R4: A weight whose magnitude is at most the threshold produces 2'b00, so a weight equal to +threshold or -threshold lands in the zero band.
- R5: The tensor holds N = 2^`len_log2` elements. The threshold, visible on `threshold` during the second pass, is the sum of the N magnitudes shifted right by `len_log2`, which truncates toward zero.
- R6: The weight -32768 counts as magnitude 32768 in the sum and in the comparison, with no wrap to a negative value.
- R7: A `start` pulse seen while idle latches `len_log2`. Any value above the buffer depth exponent (8) is clamped to 8, which gives 256 elements. `in_ready` is high only while weights are being collected, and exactly N weights are accepted. A `start` pulse while busy is ignored.
- R8: The block emits exactly N codes, in the order the weights arrived. While `out_ready` is low, `out_valid` and `out_code` hold and no code is lost.
- R9: `done` is high for exactly one cycle, in the cycle after the handshake of the final code.
- R10: `scale_out` takes `scale_wr_data` on the clock edge where `scale_wr` is high and otherwise holds. It has no effect on the codes or on the threshold.
- R11: After reset, `in_ready`, `out_valid` and `done` are low and `scale_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a tensor |
| len_log2 | input | 4 | Element count exponent, N = 2^len_log2 |
| in_valid | input | 1 | Input weight valid |
| in_ready | output | 1 | Block accepts a weight |
| in_weight | input | 16 | Two's complement weight |
| out_valid | output | 1 | Output code valid |
| out_ready | input | 1 | Consumer takes the code |
| out_code | output | 2 | Ternary code |
| done | output | 1 | One-cycle pulse after the final code |
| threshold | output | 17 | Mean magnitude of the current tensor |
| scale_wr | input | 1 | Load the scale register |
| scale_wr_data | input | 16 | New scale value |
| scale_out | output | 16 | Held scale factor |

## Verification
The bench aims at the dead-zone boundaries: tensors whose weights equal plus or minus the mean. A comparison with the wrong strictness would turn those zeros into +1 or -1. It feeds tensors full of -32768 and mixes of -32768 with 32767. A magnitude taken in 16 bits would wrap there and give a negative sum, so the threshold and the codes would flip. Sums that do not divide evenly check that the division truncates. Random gaps on both streams catch a replay that drops or repeats a code under back-pressure, as well as a done pulse that comes early or lasts more than one cycle.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CALC, ST_EMIT} tq_state_e;
  localparam logic [1:0] CODE_ZERO = 2'b00;
  localparam logic [1:0] CODE_POS  = 2'b01;
  localparam logic [1:0] CODE_NEG  = 2'b11;
endpackage

// File: rtl/tq_weight_buf.sv
module tq_weight_buf #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tq_abs_accum.sv
module tq_abs_accum #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          acc_en,
  input  logic [DW-1:0] data,
  input  logic          latch,
  input  logic [LW-1:0] shift,
  output logic [DW:0]   thr
);
  localparam int SW = DW + 1 + AW;

  logic [DW:0]   ext;
  logic [DW:0]   mag;
  logic [SW-1:0] sum_q;
  logic [SW-1:0] thr_full;

  // widen before negation so the most negative input stays positive
  assign ext = {data[DW-1], data};
  assign mag = ext[DW] ? (~ext + 1'b1) : ext;

  always_ff @(posedge clk) begin
    if (rst || clear) sum_q <= '0;
    else if (acc_en)  sum_q <= sum_q + SW'(mag);
  end

  always_ff @(posedge clk) begin
    if (rst)        thr_full <= '0;
    else if (latch) thr_full <= sum_q >> shift;
  end

  assign thr = thr_full[DW:0];

  assert_abs_range_R6: assert property (@(posedge clk) disable iff (rst)
    acc_en |-> (mag <= (DW+1)'(1 << (DW-1))) && ((mag == '0) == (data == '0)));

  assert_thr_fits_R5: assert property (@(posedge clk) disable iff (rst)
    latch |=> (thr_full >> (DW+1)) == '0);
endmodule

// File: rtl/tq_classify.sv
module tq_classify #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] w,
  input  logic [DW:0]   thr,
  output logic [1:0]    code
);
  import tq_pkg::*;

  logic signed [DW+1:0] ws;
  logic signed [DW+1:0] ts;

  assign ws = {{2{w[DW-1]}}, w};
  assign ts = {1'b0, thr};

  always_comb begin
    if (ws > ts)       code = CODE_POS;
    else if (ws < -ts) code = CODE_NEG;
    else               code = CODE_ZERO;
  end
endmodule

// File: rtl/ternary_quantizer.sv
module ternary_quantizer #(
  parameter int DATA_W     = 16,
  parameter int DEPTH_LOG2 = 8,
  parameter int SCALE_W    = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 start,
  input  logic [$clog2(DEPTH_LOG2+1)-1:0]      len_log2,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [DATA_W-1:0]                    in_weight,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic [1:0]                           out_code,
  output logic                                 done,
  output logic [DATA_W:0]                      threshold,
  input  logic                                 scale_wr,
  input  logic [SCALE_W-1:0]                   scale_wr_data,
  output logic [SCALE_W-1:0]                   scale_out
);
  import tq_pkg::*;

  localparam int LEN_W = $clog2(DEPTH_LOG2 + 1);
  localparam int AW    = DEPTH_LOG2;
  localparam int CNT_W = DEPTH_LOG2 + 1;

  tq_state_e         state_q;
  logic [LEN_W-1:0]  shift_q, shift_eff;
  logic [CNT_W-1:0]  len_q, wr_cnt, rd_cnt, out_cnt;
  logic              pipe_v;
  logic              out_valid_q, done_q;
  logic [1:0]        out_code_q, cls_code;
  logic [SCALE_W-1:0] scale_q;
  logic [DATA_W-1:0] rd_data;

  logic in_fire, out_adv, issue, out_fire, acc_clear, thr_latch;

  assign shift_eff = (len_log2 > LEN_W'(DEPTH_LOG2)) ? LEN_W'(DEPTH_LOG2) : len_log2;
  assign in_ready  = (state_q == ST_LOAD);
  assign in_fire   = in_valid && in_ready;
  assign out_adv   = pipe_v && (!out_valid_q || out_ready);
  assign issue     = (state_q == ST_EMIT) && (rd_cnt < len_q) && (!pipe_v || out_adv);
  assign out_fire  = out_valid_q && out_ready;
  assign acc_clear = (state_q == ST_IDLE) && start;
  assign thr_latch = (state_q == ST_CALC);

  tq_weight_buf #(.DW(DATA_W), .AW(AW)) u_buf (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_addr (wr_cnt[AW-1:0]),
    .wr_data (in_weight),
    .rd_en   (issue),
    .rd_addr (rd_cnt[AW-1:0]),
    .rd_data (rd_data)
  );

  tq_abs_accum #(.DW(DATA_W), .AW(AW), .LW(LEN_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clear  (acc_clear),
    .acc_en (in_fire),
    .data   (in_weight),
    .latch  (thr_latch),
    .shift  (shift_q),
    .thr    (threshold)
  );

  tq_classify #(.DW(DATA_W)) u_cls (
    .w    (rd_data),
    .thr  (threshold),
    .code (cls_code)
  );

  // pass sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      len_q   <= '0;
      wr_cnt  <= '0;
      rd_cnt  <= '0;
      out_cnt <= '0;
      pipe_v  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          shift_q <= shift_eff;
          len_q   <= CNT_W'(1) << shift_eff;
          wr_cnt  <= '0;
          state_q <= ST_LOAD;
        end
        ST_LOAD: if (in_fire) begin
          wr_cnt <= wr_cnt + 1'b1;
          if (wr_cnt == len_q - 1'b1) state_q <= ST_CALC;
        end
        ST_CALC: begin
          rd_cnt  <= '0;
          out_cnt <= '0;
          pipe_v  <= 1'b0;
          state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          if (issue) rd_cnt <= rd_cnt + 1'b1;
          pipe_v <= issue || (pipe_v && !out_adv);
          if (out_fire) begin
            out_cnt <= out_cnt + 1'b1;
            if (out_cnt == len_q - 1'b1) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_code_q  <= CODE_ZERO;
    end else if (out_adv) begin
      out_valid_q <= 1'b1;
      out_code_q  <= cls_code;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           scale_q <= '0;
    else if (scale_wr) scale_q <= scale_wr_data;
  end

  assign out_valid = out_valid_q;
  assign out_code  = out_code_q;
  assign done      = done_q;
  assign scale_out = scale_q;

  assert_legal_code_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid_q |-> (out_code_q != 2'b10));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid_q && !out_ready) |=> (out_valid_q && $stable(out_code_q)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_scale_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !scale_wr |=> $stable(scale_q));

  assert_accept_bound_R7: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (wr_cnt < len_q) && !out_valid_q);

  assert_emit_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EMIT) |-> (out_cnt <= rd_cnt) && (rd_cnt <= len_q));
endmodule

// File: tb/tb_ternary_quantizer.sv
module tb_ternary_quantizer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  len_log2 = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_weight = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [1:0]  out_code;
  logic        done;
  logic [16:0] threshold;
  logic        scale_wr = 1'b0;
  logic [15:0] scale_wr_data = '0;
  logic [15:0] scale_out;

  int checks = 0;
  int errors = 0;
  logic signed [15:0] w [256];
  bit mon_done;

  always #5 clk = ~clk;

  ternary_quantizer dut (
    .clk(clk), .rst(rst), .start(start), .len_log2(len_log2),
    .in_valid(in_valid), .in_ready(in_ready), .in_weight(in_weight),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .done(done), .threshold(threshold), .scale_wr(scale_wr),
    .scale_wr_data(scale_wr_data), .scale_out(scale_out)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_thr(int n);
    longint s = 0;
    for (int i = 0; i < n; i++) s += (w[i] < 0) ? -longint'(w[i]) : longint'(w[i]);
    return int'(s / n);
  endfunction

  function automatic logic [1:0] exp_code(int v, int t);
    if (v > t) return 2'b01;
    if (v < -t) return 2'b11;
    return 2'b00;
  endfunction

  task automatic run_tensor(int lg, string tag);
    int eff = (lg > 8) ? 8 : lg;
    int n = 1 << eff;
    int t = exp_thr(n);
    mon_done = 0;
    @(negedge clk);
    start = 1'b1; len_log2 = 4'(lg);
    @(negedge clk);
    start = 1'b0;
    fork
      begin : drv
        int idx = 0;
        while (idx < n) begin
          in_valid  = ($urandom % 4) != 0;
          in_weight = w[idx];
          #1;
          if (in_valid && in_ready) idx++;
          @(negedge clk);
        end
        while (!mon_done) begin
          in_valid = 1'b1; in_weight = 16'h7fff;
          #1;
          if (in_ready) check(0, "R7", "extra weight accepted", 1, 0);
          @(negedge clk);
        end
        in_valid = 1'b0;
      end
      begin : mon
        int got = 0;
        while (got < n) begin
          @(negedge clk);
          out_ready = ($urandom % 3) != 0;
          #1;
          if (out_valid) begin
            check(out_code != 2'b10, "R1", {tag, " illegal code"}, out_code, 0);
            if (got == 0)
              check(threshold == 17'(t), "R5", {tag, " threshold"}, threshold, t);
          end
          if (out_valid && out_ready) begin
            logic [1:0] e = exp_code(w[got], t);
            string rq = (e == 2'b01) ? "R2" : (e == 2'b11) ? "R3" : "R4";
            check(out_code == e, rq, {tag, " code (R8 order)"}, out_code, e);
            got++;
            if (got < n) check(done == 1'b0, "R9", {tag, " early done"}, done, 0);
          end
        end
        @(negedge clk);
        out_ready = 1'b0;
        check(done == 1'b1, "R9", {tag, " done pulse"}, done, 1);
        check(out_valid == 1'b0, "R8", {tag, " extra code"}, out_valid, 0);
        @(negedge clk);
        check(done == 1'b0, "R9", {tag, " done width"}, done, 0);
        mon_done = 1;
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 0 && out_valid == 0 && done == 0, "R11", "reset handshake", int'({in_ready, out_valid, done}), 0);
    check(scale_out == 0, "R11", "reset scale", scale_out, 0);

    scale_wr = 1'b1; scale_wr_data = 16'h1234;
    @(negedge clk);
    scale_wr = 1'b0;
    check(scale_out == 16'h1234, "R10", "scale load", scale_out, 16'h1234);

    for (int i = 0; i < 8; i++) w[i] = 0;
    run_tensor(3, "zeros");

    w[0] = -16'sd32768;
    run_tensor(0, "single min");

    w[0] = -16'sd32768; w[1] = 16'sd32767;
    run_tensor(1, "min max R6");

    for (int i = 0; i < 16; i++) w[i] = -16'sd32768;
    run_tensor(4, "all min R6");

    w[0] = 5; w[1] = -3; w[2] = 4; w[3] = -4;
    run_tensor(2, "tie band");

    w[0] = 1; w[1] = -1; w[2] = 1; w[3] = 0;
    run_tensor(2, "truncate");

    for (int i = 0; i < 32; i++) w[i] = 16'(int'($urandom % 17) - 8);
    run_tensor(5, "small range");

    for (int i = 0; i < 256; i++) w[i] = 16'($urandom);
    run_tensor(8, "full range");

    for (int i = 0; i < 256; i++) w[i] = 16'(int'($urandom % 2001) - 1000);
    run_tensor(12, "clamped length");

    check(scale_out == 16'h1234, "R10", "scale held", scale_out, 16'h1234);

    @(negedge clk);
    check(in_ready == 0, "R7", "idle not ready", in_ready, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule